// File: doc/BRIEF.md
# SPI Master with Gap-Free Frame Hold

This block is a clocked-serial master for clock mode 0: the serial clock rests low, and the master updates the outgoing data while the clock is low. Both sides capture data on the rising edge. Words to send sit in an eight-entry transmit queue. Each word shifts out most significant bit first. The word received over the same bits is pushed into an eight-entry receive queue. The serial clock is a whole-number division of the system clock, and its two halves are always equal.

There are two framing styles. In the per-word style, every word gets its own chip-select window. Chip select goes high between words even when the next word is already queued, and the word length can be set from 4 to 16 bits. In the held style, the word length is fixed at 8 bits and chip select stays low across a run of words. The clock keeps an even cadence across word boundaries. The run ends after a word that carries an end tag. The host raises a one-shot end flag before writing the closing word. That flag is stored in bit 12 of the queue entry and clears itself once it has been used. If the queue runs dry before the tagged word arrives, the frame stays open with the clock parked low.

Top module: `spi_frame_master`

## Requirements
- R1: After reset, cs_n=1, sclk=0, busy=0, tx_empty=1, tx_full=0 and rx_nempty=0.
- R2: Mode 0 timing. sclk is low whenever cs_n is high. mosi never changes on a rising sclk edge. Words go out most significant bit first. miso is sampled on each rising edge, and those bits form the received word, first bit most significant.
- R3: With cfg_hold=0, each word has its own cs_n low window, even when the next word is queued. From the last rising edge of one word to the first rising edge of the next there are exactly 5*H+1 system clocks, where H is the half-period setting.
- R4: At the end of every frame, cs_n rises exactly 2*H system clocks (one serial period) after the last rising sclk edge.
- R5: With cfg_hold=1, cs_n stays low across consecutive words. Every rising edge in the frame follows the previous one by exactly 2*H system clocks, including across word boundaries, and each high phase lasts exactly H system clocks.
- R6: In held mode, a queue entry's end tag is its bit 12. The frame closes after the word that carries the tag. Data bit 12 written by the host is not a tag.
- R7: eom_set sets a flag that tags the next accepted write (a write in the same cycle is also tagged). The flag clears on that write, so the word after it is untagged.
- R8: In held mode, if the queue empties before a tagged word is sent, cs_n stays low, sclk stays low and busy stays high. The same frame resumes when a word is written.
- R9: In held mode a word is tx_data[7:0]. Otherwise a word is the low cfg_size+1 bits of tx_data, with cfg_size values below 3 acting as 3. Received words appear in the low bits of rx_data, with the upper bits zero.
- R10: Each sclk half lasts cfg_half system clocks. With cfg_half=15, a 120 MHz system clock gives 4 MHz with a steady 250 ns bit time.
- R11: Each queue holds 8 entries. tx_full and tx_empty report the transmit queue state. A write while full is ignored. A received word that arrives while the receive queue is full is dropped.
- R12: busy is high from the moment a word is taken from the queue until the closing chip-select gap ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_hold | input | 1 | 1 selects held multi-word frames |
| cfg_size | input | 4 | Word length minus one for per-word mode |
| cfg_half | input | 8 | System clocks per sclk half-period |
| tx_wr | input | 1 | Write tx_data into the transmit queue |
| tx_data | input | 16 | Word to transmit |
| eom_set | input | 1 | Arm the end tag for the next write |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_rd | input | 1 | Remove the head of the receive queue |
| rx_data | output | 16 | Head of the receive queue |
| rx_nempty | output | 1 | Receive queue holds a word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | A frame is in progress |

## Verification
The delicate collision is a word finishing its last bit in the same cycle that the queue must supply the next word, while the host may also be writing. In held mode, this pop must load the next word without losing a half-period. The bench queues words ahead of time and also writes bursts while a frame is running. It judges the result by the exact spacing of every rising edge across word boundaries. A second collision is the end flag being armed and consumed around back-to-back writes. This is provoked by arming the flag once and then writing two words. The judgement is whether the frame closes after the first word and parks after the second.

// File: rtl/spifh_pkg.sv
package spifh_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOW,
      ST_HIGH,
      ST_PARK,
      ST_TAIL,
      ST_GAP
   } spifh_state_e;

   // states during which the half-period divider runs
   function automatic logic spifh_runs(input spifh_state_e s);
      return (s == ST_LOW) || (s == ST_HIGH) || (s == ST_TAIL) || (s == ST_GAP);
   endfunction
endpackage

// File: rtl/spifh_fifo.sv
module spifh_fifo #(
   parameter int unsigned W     = 16,
   parameter int unsigned DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         empty,
   output logic         full
);
   localparam int unsigned AW = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("spifh_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [AW:0]   cnt_q;
   logic          wr_ok, rd_ok;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == (AW+1)'(DEPTH));
   assign wr_ok   = wr_en && !full;
   assign rd_ok   = rd_en && !empty;
   assign rd_data = mem[rp_q];

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wp_q] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (wr_ok) wp_q <= wp_q + 1'b1;
         if (rd_ok) rp_q <= rp_q + 1'b1;
         case ({wr_ok, rd_ok})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   // the consumer must only pop an entry that exists
   assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> !empty);
endmodule

// File: rtl/spifh_baud.sv
module spifh_baud #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] cfg_half,
   output logic             tick
);
   logic [DIV_W-1:0] half_eff;
   logic [DIV_W-1:0] cnt_q;

   assign half_eff = (cfg_half == '0) ? DIV_W'(1) : cfg_half;
   assign tick     = run && (cnt_q == half_eff - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (!run)  cnt_q <= '0;
      else if (tick)  cnt_q <= '0;
      else            cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/spifh_engine.sv
module spifh_engine
   import spifh_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned HOLD_BITS = 8,
   parameter int unsigned EOM_POS   = 12,
   parameter int unsigned MIN_BITS  = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       tick,
   input  logic                       cfg_hold,
   input  logic [$clog2(DATA_W)-1:0]  cfg_size,
   input  logic                       txq_empty,
   input  logic [DATA_W-1:0]          txq_data,
   output logic                       txq_pop,
   output logic                       rxq_push,
   output logic [DATA_W-1:0]          rxq_data,
   input  logic                       miso,
   output logic                       sclk,
   output logic                       mosi,
   output logic                       cs_n,
   output logic                       busy,
   output logic                       run
);
   localparam int unsigned SW = $clog2(DATA_W);
   localparam logic [SW-1:0] HOLD_WMAX = SW'(HOLD_BITS - 1);
   localparam logic [SW-1:0] MIN_WMAX  = SW'(MIN_BITS - 1);
   localparam logic [SW-1:0] TOP_IDX   = SW'(DATA_W - 1);

   spifh_state_e      state_q;
   logic [DATA_W-1:0] tx_sh_q, rx_sh_q;
   logic [SW-1:0]     bits_left_q, wmax_q;
   logic              eom_q, hold_q, gap2_q, sclk_q, cs_n_q;

   // next-word load path
   logic              load_hold, load_eom;
   logic [SW-1:0]     load_wmax;
   logic [SW:0]       load_cnt, cur_cnt;
   logic [DATA_W-1:0] load_mask, load_word, rx_mask;

   assign load_hold = (state_q == ST_IDLE) ? cfg_hold : hold_q;
   assign load_wmax = load_hold ? HOLD_WMAX :
                      ((cfg_size < MIN_WMAX) ? MIN_WMAX : cfg_size);
   assign load_cnt  = {1'b0, load_wmax} + {{SW{1'b0}}, 1'b1};
   assign load_mask = ~({DATA_W{1'b1}} << load_cnt);
   assign load_word = (txq_data & load_mask) << (TOP_IDX - load_wmax);
   assign load_eom  = load_hold && txq_data[EOM_POS];

   assign cur_cnt   = {1'b0, wmax_q} + {{SW{1'b0}}, 1'b1};
   assign rx_mask   = ~({DATA_W{1'b1}} << cur_cnt);
   assign rxq_data  = rx_sh_q & rx_mask;

   assign sclk = sclk_q;
   assign cs_n = cs_n_q;
   assign mosi = tx_sh_q[DATA_W-1];
   assign busy = (state_q != ST_IDLE);
   assign run  = spifh_runs(state_q);

   always_comb begin
      txq_pop  = 1'b0;
      rxq_push = 1'b0;
      unique case (state_q)
         ST_IDLE: txq_pop = !txq_empty;
         ST_HIGH: if (tick && bits_left_q == '0) begin
            rxq_push = 1'b1;
            txq_pop  = hold_q && !eom_q && !txq_empty;
         end
         ST_PARK: txq_pop = !txq_empty;
         default: ;
      endcase
   end

   // data path: load on pop, shift on each falling edge within a word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh_q     <= '0;
         bits_left_q <= '0;
         wmax_q      <= HOLD_WMAX;
         eom_q       <= 1'b0;
      end else if (txq_pop) begin
         tx_sh_q     <= load_word;
         bits_left_q <= load_wmax;
         wmax_q      <= load_wmax;
         eom_q       <= load_eom;
      end else if (state_q == ST_HIGH && tick && bits_left_q != '0) begin
         tx_sh_q     <= {tx_sh_q[DATA_W-2:0], 1'b0};
         bits_left_q <= bits_left_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rx_sh_q <= '0;
      else if (state_q == ST_LOW && tick)
         rx_sh_q <= {rx_sh_q[DATA_W-2:0], miso};
   end

   // framing state machine
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sclk_q  <= 1'b0;
         cs_n_q  <= 1'b1;
         hold_q  <= 1'b0;
         gap2_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (txq_pop) begin
               hold_q  <= cfg_hold;
               cs_n_q  <= 1'b0;
               state_q <= ST_LOW;
            end
            ST_LOW: if (tick) begin
               sclk_q  <= 1'b1;
               state_q <= ST_HIGH;
            end
            ST_HIGH: if (tick) begin
               sclk_q <= 1'b0;
               if (bits_left_q != '0)       state_q <= ST_LOW;
               else if (txq_pop)            state_q <= ST_LOW;
               else if (hold_q && !eom_q)   state_q <= ST_PARK;
               else                         state_q <= ST_TAIL;
            end
            ST_PARK: if (txq_pop) state_q <= ST_LOW;
            ST_TAIL: if (tick) begin
               cs_n_q  <= 1'b1;
               gap2_q  <= 1'b0;
               state_q <= ST_GAP;
            end
            ST_GAP: if (tick) begin
               if (gap2_q) state_q <= ST_IDLE;
               else        gap2_q  <= 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assert_idle_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_q |-> !sclk_q);
   assert_mosi_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk_q) |-> $stable(mosi));
   assert_cs_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n_q) |=> cs_n_q);
   assert_park_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PARK) |-> (!cs_n_q && !sclk_q));
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master #(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned FIFO_DEPTH = 8,
   parameter int unsigned DIV_W      = 8,
   parameter int unsigned HOLD_BITS  = 8,
   parameter int unsigned EOM_POS    = 12,
   parameter int unsigned MIN_BITS   = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_hold,
   input  logic [$clog2(DATA_W)-1:0] cfg_size,
   input  logic [DIV_W-1:0]          cfg_half,
   input  logic                      tx_wr,
   input  logic [DATA_W-1:0]         tx_data,
   input  logic                      eom_set,
   output logic                      tx_full,
   output logic                      tx_empty,
   input  logic                      rx_rd,
   output logic [DATA_W-1:0]         rx_data,
   output logic                      rx_nempty,
   output logic                      sclk,
   output logic                      mosi,
   input  logic                      miso,
   output logic                      cs_n,
   output logic                      busy
);
   localparam int unsigned SW = $clog2(DATA_W);

   if ((1 << SW) != DATA_W) begin : g_bad_width
      $error("spi_frame_master: DATA_W must be a power of two");
   end
   if (EOM_POS >= DATA_W || EOM_POS < HOLD_BITS || HOLD_BITS > DATA_W) begin : g_bad_tag
      $error("spi_frame_master: end tag must sit above the held word and inside the entry");
   end
   if (MIN_BITS < 2 || MIN_BITS > DATA_W) begin : g_bad_min
      $error("spi_frame_master: MIN_BITS out of range");
   end

   logic              eom_flag_q, tag, wr_ok;
   logic [DATA_W-1:0] tx_entry, txq_data, rxq_data;
   logic              txq_pop, rxq_push, rx_empty, rx_full_unused;
   logic              tick, run;

   assign tag   = eom_flag_q | eom_set;
   assign wr_ok = tx_wr && !tx_full;

   always_comb begin
      tx_entry = tx_data;
      if (cfg_hold) tx_entry[EOM_POS] = tag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       eom_flag_q <= 1'b0;
      else if (wr_ok)   eom_flag_q <= 1'b0;
      else if (eom_set) eom_flag_q <= 1'b1;
   end

   spifh_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .wr_en(tx_wr), .wr_data(tx_entry),
      .rd_en(txq_pop), .rd_data(txq_data),
      .empty(tx_empty), .full(tx_full)
   );

   spifh_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .wr_en(rxq_push), .wr_data(rxq_data),
      .rd_en(rx_rd && !rx_empty), .rd_data(rx_data),
      .empty(rx_empty), .full(rx_full_unused)
   );

   assign rx_nempty = !rx_empty;

   spifh_baud #(.DIV_W(DIV_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .run(run), .cfg_half(cfg_half), .tick(tick)
   );

   spifh_engine #(
      .DATA_W(DATA_W), .HOLD_BITS(HOLD_BITS), .EOM_POS(EOM_POS), .MIN_BITS(MIN_BITS)
   ) u_eng (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .cfg_hold(cfg_hold), .cfg_size(cfg_size),
      .txq_empty(tx_empty), .txq_data(txq_data), .txq_pop(txq_pop),
      .rxq_push(rxq_push), .rxq_data(rxq_data),
      .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
      .busy(busy), .run(run)
   );

   // an accepted write consumes an armed end flag
   assert_eom_consumed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && !eom_set) |=> !eom_flag_q);
endmodule

// File: tb/spi_frame_master_test.sv
module spi_frame_master_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_hold = 1'b0;
   logic [3:0]  cfg_size = 4'd7;
   logic [7:0]  cfg_half = 8'd2;
   logic        tx_wr = 1'b0;
   logic [15:0] tx_data = '0;
   logic        eom_set = 1'b0;
   logic        rx_rd = 1'b0;
   logic        miso = 1'b0;
   logic        tx_full, tx_empty, rx_nempty, sclk, mosi, cs_n, busy;
   logic [15:0] rx_data;

   always #10 clk = ~clk;

   spi_frame_master uut (
      .clk(clk), .rst_n(rst_n), .cfg_hold(cfg_hold), .cfg_size(cfg_size),
      .cfg_half(cfg_half), .tx_wr(tx_wr), .tx_data(tx_data), .eom_set(eom_set),
      .tx_full(tx_full), .tx_empty(tx_empty), .rx_rd(rx_rd), .rx_data(rx_data),
      .rx_nempty(rx_nempty), .sclk(sclk), .mosi(mosi), .miso(miso),
      .cs_n(cs_n), .busy(busy)
   );

   int checks = 0, errors = 0;
   bit done = 0;
   int cyc = 0, nr = 0, nf = 0, cs_rises = 0, cs_rise_t = 0;
   int rise_t [1024];
   int fall_t [1024];
   bit mbits  [1024];
   logic p_sclk = 1'b0, p_cs = 1'b1;

   function automatic bit sb(int k);
      int t;
      t = (k * 5 + k / 4) / 2;
      return (t % 2) == 1;
   endfunction

   // slave model and edge monitor, away from the active edge
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (!p_sclk && sclk) begin
            if (nr < 1024) begin rise_t[nr] = cyc; mbits[nr] = mosi; end
            nr++;
            miso = sb(nr);
         end
         if (p_sclk && !sclk) begin
            if (nf < 1024) fall_t[nf] = cyc;
            nf++;
         end
         if (!p_cs && cs_n) begin cs_rises++; cs_rise_t = cyc; end
      end
      p_sclk = sclk;
      p_cs   = cs_n;
   end

   function automatic int rx_exp(int k0, int n);
      int v = 0;
      for (int i = 0; i < n; i++) v = (v << 1) | int'(sb(k0 + i));
      return v;
   endfunction

   function automatic int tx_word(int k0, int n);
      int v = 0;
      for (int i = 0; i < n; i++) v = (v << 1) | int'(mbits[k0 + i]);
      return v;
   endfunction

   task automatic chk_eq(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic put(logic [15:0] d, bit e);
      tx_data = d; eom_set = e; tx_wr = 1'b1;
      @(negedge clk);
      tx_wr = 1'b0; eom_set = 1'b0;
   endtask

   task automatic arm_eom();
      eom_set = 1'b1;
      @(negedge clk);
      eom_set = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      while ((busy || !tx_empty) && n < 20000) begin @(negedge clk); n++; end
      if (n >= 20000) chk_eq("R12 frame never ended", 1, 0);
      repeat (2) @(negedge clk);
   endtask

   task automatic read_rx(string tag, int exp);
      chk_eq({tag, " rx_nempty"}, int'(rx_nempty), 1);
      chk_eq(tag, int'(rx_data), exp);
      rx_rd = 1'b1;
      @(negedge clk);
      rx_rd = 1'b0;
   endtask

   task automatic check_cadence(string tag, int k0, int cnt, int half);
      int bad = -1, act = 0, exp = 0;
      for (int i = 0; i < cnt; i++) begin
         if (bad < 0 && fall_t[k0+i] - rise_t[k0+i] != half) begin
            bad = i; act = fall_t[k0+i] - rise_t[k0+i]; exp = half;
         end
         if (bad < 0 && i < cnt - 1 && rise_t[k0+i+1] - rise_t[k0+i] != 2 * half) begin
            bad = i; act = rise_t[k0+i+1] - rise_t[k0+i]; exp = 2 * half;
         end
      end
      chk_eq(tag, act, exp);
   endtask

   initial begin
      int b, c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk_eq("R1 cs_n", int'(cs_n), 1);
      chk_eq("R1 sclk", int'(sclk), 0);
      chk_eq("R1 busy", int'(busy), 0);
      chk_eq("R1 tx_empty", int'(tx_empty), 1);
      chk_eq("R1 tx_full", int'(tx_full), 0);
      chk_eq("R1 rx_nempty", int'(rx_nempty), 0);

      // per-word framing, 8-bit words, queued ahead
      b = nr; c = cs_rises;
      put(16'h00A5, 0); put(16'h003C, 0); put(16'h00F0, 0);
      chk_eq("R12 busy while sending", int'(busy), 1);
      wait_idle();
      chk_eq("R12 busy after frame", int'(busy), 0);
      chk_eq("R3 bit count", nr - b, 24);
      chk_eq("R3 separate windows", cs_rises - c, 3);
      chk_eq("R2 word0 msb first", tx_word(b, 8), 'hA5);
      chk_eq("R2 word1", tx_word(b + 8, 8), 'h3C);
      chk_eq("R2 word2", tx_word(b + 16, 8), 'hF0);
      chk_eq("R3 inter-word spacing", rise_t[b+8] - rise_t[b+7], 5 * 2 + 1);
      chk_eq("R4 release delay", cs_rise_t - rise_t[b+23], 4);
      read_rx("R2 rx0", rx_exp(b, 8));
      read_rx("R2 rx1", rx_exp(b + 8, 8));
      read_rx("R2 rx2", rx_exp(b + 16, 8));

      // word sizes in per-word mode
      cfg_size = 4'd11; b = nr;
      put(16'h5ABC, 0); wait_idle();
      chk_eq("R9 12-bit count", nr - b, 12);
      chk_eq("R9 12-bit word", tx_word(b, 12), 'hABC);
      read_rx("R9 12-bit rx", rx_exp(b, 12));
      cfg_size = 4'd15; b = nr;
      put(16'hC3A5, 0); wait_idle();
      chk_eq("R9 16-bit word", tx_word(b, 16), 'hC3A5);
      read_rx("R9 16-bit rx", rx_exp(b, 16));
      cfg_size = 4'd1; b = nr;
      put(16'h00FE, 0); wait_idle();
      chk_eq("R9 size floor count", nr - b, 4);
      chk_eq("R9 size floor word", tx_word(b, 4), 'hE);
      read_rx("R9 size floor rx", rx_exp(b, 4));

      // held frame of three words, tag on the last
      cfg_hold = 1'b1; cfg_size = 4'd15; b = nr; c = cs_rises;
      put(16'h1255, 0); put(16'h00AA, 0); put(16'hFFC3, 1);
      wait_idle();
      chk_eq("R5 bit count", nr - b, 24);
      chk_eq("R5 single window", cs_rises - c, 1);
      check_cadence("R5 gap-free cadence", b, 24, 2);
      chk_eq("R6 data bit12 not a tag", tx_word(b, 8), 'h55);
      chk_eq("R9 held word1", tx_word(b + 8, 8), 'hAA);
      chk_eq("R9 held word2", tx_word(b + 16, 8), 'hC3);
      chk_eq("R4 held release delay", cs_rise_t - rise_t[b+23], 4);
      read_rx("R9 held rx0", rx_exp(b, 8));
      read_rx("R9 held rx1", rx_exp(b + 8, 8));
      read_rx("R9 held rx2", rx_exp(b + 16, 8));

      // queue runs dry inside a held frame
      b = nr; c = cs_rises;
      put(16'h0011, 0);
      repeat (80) @(negedge clk);
      chk_eq("R8 cs held low", int'(cs_n), 0);
      chk_eq("R8 clock parked", int'(sclk), 0);
      chk_eq("R8 busy parked", int'(busy), 1);
      chk_eq("R8 bits before park", nr - b, 8);
      chk_eq("R8 no release", cs_rises - c, 0);
      put(16'h0022, 1);
      wait_idle();
      chk_eq("R8 resumed window", cs_rises - c, 1);
      chk_eq("R8 resumed word", tx_word(b + 8, 8), 'h22);
      read_rx("R8 rx0", rx_exp(b, 8));
      read_rx("R8 rx1", rx_exp(b + 8, 8));

      // armed flag tags one write only
      b = nr; c = cs_rises;
      arm_eom();
      put(16'h000F, 0); put(16'h0070, 0);
      repeat (100) @(negedge clk);
      chk_eq("R7 first word closed frame", cs_rises - c, 1);
      chk_eq("R7 second word untagged", int'(cs_n), 0);
      chk_eq("R7 bits so far", nr - b, 16);
      put(16'h0081, 1);
      wait_idle();
      chk_eq("R6 tag closes frame", cs_rises - c, 2);
      chk_eq("R7 word0", tx_word(b, 8), 'h0F);
      chk_eq("R7 word1", tx_word(b + 8, 8), 'h70);
      read_rx("R7 rx0", rx_exp(b, 8));
      read_rx("R7 rx1", rx_exp(b + 8, 8));
      read_rx("R7 rx2", rx_exp(b + 16, 8));

      // queue limits with 4-bit words at the fastest divider
      cfg_hold = 1'b0; cfg_size = 4'd3; cfg_half = 8'd1; b = nr; c = cs_rises;
      for (int i = 0; i < 10; i++) put(16'(i + 1), 0);
      chk_eq("R11 tx_full", int'(tx_full), 1);
      wait_idle();
      chk_eq("R11 write while full ignored", nr - b, 36);
      chk_eq("R11 windows", cs_rises - c, 9);
      begin
         int badw = 0;
         for (int i = 0; i < 9; i++) if (tx_word(b + 4 * i, 4) != i + 1) badw++;
         chk_eq("R11 queued words in order", badw, 0);
      end
      for (int i = 0; i < 8; i++) read_rx("R11 rx kept", rx_exp(b + 4 * i, 4));
      chk_eq("R11 ninth rx dropped", int'(rx_nempty), 0);
      chk_eq("R11 tx_empty", int'(tx_empty), 1);

      // 4 MHz from 120 MHz ratio: half of 15
      cfg_hold = 1'b1; cfg_half = 8'd15; b = nr;
      put(16'h0096, 0); put(16'h0069, 0); put(16'h005A, 1);
      wait_idle();
      check_cadence("R10 half of 15 cadence", b, 24, 15);
      chk_eq("R10 release delay", cs_rise_t - rise_t[b+23], 30);
      chk_eq("R10 word2", tx_word(b + 16, 8), 'h5A);
      read_rx("R10 rx0", rx_exp(b, 8));
      read_rx("R10 rx1", rx_exp(b + 8, 8));
      read_rx("R10 rx2", rx_exp(b + 16, 8));

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule